// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave side of a serial flash interface for SPI mode 0. The first eight bits clocked in after chip select falls are taken as the instruction. The block keeps the write-enable latch that guards every content-changing operation. It also answers the identification instruction with three fixed bytes on the serial output. A separate program/erase engine reports the end of each of its operations through completion pulses, which clear the latch. That engine also drives a busy level, and the identification instruction is not decoded while busy is high.

The SPI pins are oversampled by a faster system clock. Chip select, serial clock and serial in pass through two-flop synchronizers, and their edges are found in the system clock domain. All state therefore lives in one clock domain, and the serial clock must stay at least four system clocks high and four low. The serial output is a data bit plus an output-enable. The enable stands for the tri-state driver that the pad ring builds around it.

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: After reset, `wel` is 0 and `miso_oe` is 0.
- R2: Opcode 8'h06 sets `wel` to 1. It takes effect only when it is clocked in MSB first on rising serial clock edges and chip select rises after exactly eight bits.
- R3: Opcode 8'h04 clears `wel` to 0, with the same exact-eight-bit rule as R2.
- R4: A command that ends with fewer or more than eight bits leaves `wel` unchanged. So does any opcode other than 8'h06 and 8'h04.
- R5: A one-cycle pulse on any bit of `op_done` clears `wel` on the next clock. Bit 0 is write-status done, bit 1 page-program done, bit 2 sector-erase done and bit 3 chip-erase done. When a clear and a set fall in the same cycle, the clear wins.
- R6: After opcode 8'h9F, `miso` carries 24'hC22016 MSB first with `miso_oe` high. Each bit changes after a falling serial clock edge and is valid at the rising edges that follow the eighth opcode bit.
- R7: If `busy` is high when the eighth bit of opcode 8'h9F arrives, no ID is returned and `miso_oe` stays 0 for the rest of that selection. The `wel` value is not affected.
- R8: Raising chip select during the ID data phase drops `miso_oe` within eight system clocks. The next selection is then decoded normally.
- R9: `miso_oe` is 0 whenever chip select is high. It also drops at the first falling serial clock edge after the 24th ID bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out |
| miso_oe | output | 1 | Output enable for miso (0 = high impedance) |
| busy | input | 1 | Program/erase engine busy level |
| op_done | input | 4 | Completion pulses: write status, page program, sector erase, chip erase |
| wel | output | 1 | Write-enable latch value |

## Verification
The hardest case to reach from the ports is a set and a clear of the latch in the same system clock. It needs a completion pulse in exactly the cycle in which the synchronized chip-select rise commits a write-enable. The bench does not try to hit that cycle. It holds a completion bit high for the whole write-enable transaction, so the overlap is certain, and then checks that the latch stays clear. The other hard case is the ID phase being cut off after a few bits, or running past 24 bits. Both come from directed transfers whose bit counts are set so that chip select rises mid-data or one clock past the last bit.

// File: rtl/spi_fe_pkg.sv
// Package: shared opcodes, ID value and phase type for the serial flash
// command front end.
package spi_fe_pkg;
    localparam int unsigned OP_W      = 8;
    localparam int unsigned ID_W      = 24;
    localparam int unsigned N_DONE    = 4;
    localparam logic [OP_W-1:0] OP_WREN = 8'h06;
    localparam logic [OP_W-1:0] OP_WRDI = 8'h04;
    localparam logic [OP_W-1:0] OP_ID   = 8'h9F;
    localparam logic [ID_W-1:0] ID_WORD = 24'hC22016;

    typedef enum logic [1:0] {
        PH_STANDBY = 2'd0,
        PH_OPCODE  = 2'd1,
        PH_READ    = 2'd2,
        PH_TAIL    = 2'd3
    } phase_t;
endpackage

// File: rtl/spi_fe_sync.sv
// Module: spi_fe_sync
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes: each pin is held stable for several clk cycles; RST_VAL gives
// the idle level of each bit during reset.
module spi_fe_sync #(
    parameter int unsigned W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        // Two-stage capture of one pin into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= pin_in[g];
                sync_q <= meta_q;
            end
        end
        assign pin_sync[g] = sync_q;
    end
endmodule

// File: rtl/spi_fe_rx.sv
// Module: spi_fe_rx
// Shifts in serial data MSB first on each sampled rising serial clock and
// flags the cycle the first byte of a selection is complete.
// Assumes: bit_rise is a one-cycle pulse; clear is high while deselected.
module spi_fe_rx #(
    parameter int unsigned OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            bit_rise,
    input  logic            bit_in,
    output logic [OP_W-1:0] opcode,
    output logic            op_strobe,
    output logic            exact_len
);
    localparam int unsigned CNT_MAX = OP_W + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [OP_W-1:0]  sh_q;
    logic             strobe_q;

    // Bit counter saturating one past the opcode length.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (bit_rise && cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Shift register holding the most recent eight input bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (bit_rise && !clear) begin
            sh_q <= {sh_q[OP_W-2:0], bit_in};
        end
    end

    // One-cycle strobe when the last opcode bit has been shifted in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= bit_rise && !clear && cnt_q == CNT_W'(OP_W - 1);
        end
    end

    assign opcode    = sh_q;
    assign op_strobe = strobe_q;
    assign exact_len = (cnt_q == CNT_W'(OP_W));

    // R4: the strobe only appears once the count has reached exactly eight
    p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> cnt_q == CNT_W'(OP_W));
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/spi_fe_tx.sv
// Module: spi_fe_tx
// Shifts a fixed word out MSB first, one bit per sampled falling serial
// clock edge, and stops driving after the last bit or on abort.
// Assumes: load and bit_fall are one-cycle pulses; abort is a level.
module spi_fe_tx #(
    parameter int unsigned DW = 24,
    parameter logic [DW-1:0] WORD = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic load,
    input  logic bit_fall,
    output logic dout,
    output logic oe,
    output logic active
);
    localparam int unsigned CNT_W = $clog2(DW + 1);

    logic [DW-1:0]    sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             act_q;
    logic             oe_q;
    logic             dout_q;

    // Load, shift and end-of-word control of the output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b0;
            oe_q   <= 1'b0;
            dout_q <= 1'b0;
        end else if (abort) begin
            act_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (load) begin
            sh_q  <= WORD;
            cnt_q <= '0;
            act_q <= 1'b1;
            oe_q  <= 1'b0;
        end else if (act_q && bit_fall) begin
            if (cnt_q == CNT_W'(DW)) begin
                act_q <= 1'b0;
                oe_q  <= 1'b0;
            end else begin
                dout_q <= sh_q[DW-1];
                sh_q   <= {sh_q[DW-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
                oe_q   <= 1'b1;
            end
        end
    end

    assign dout   = dout_q;
    assign oe     = oe_q;
    assign active = act_q;

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DW));
    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !oe_q && !act_q);
    p_oe_needs_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> act_q);
endmodule

// File: rtl/spi_flash_cmd_fe.sv
// Module: spi_flash_cmd_fe (top)
// SPI mode-0 command front end: decodes the first byte of each selection,
// keeps the write-enable latch, and returns the ID word.
// Assumes: clk runs at least 8x sclk; busy and op_done are synchronous to clk.
module spi_flash_cmd_fe
    import spi_fe_pkg::*;
#(
    parameter int unsigned ND = N_DONE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          mosi,
    output logic          miso,
    output logic          miso_oe,
    input  logic          busy,
    input  logic [ND-1:0] op_done,
    output logic          wel
);
    logic [2:0]      pins_s;
    logic            cs_s, sclk_s, mosi_s;
    logic            cs_prev_q, sclk_prev_q;
    logic            sclk_rise, sclk_fall, cs_rise;
    logic [OP_W-1:0] rx_opcode;
    logic            rx_strobe, rx_exact;
    logic [OP_W-1:0] op_q;
    logic            id_load;
    logic            tx_active;
    logic            wel_q;
    phase_t          phase_q;

    spi_fe_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({mosi, sclk, cs_n}),
        .pin_sync (pins_s)
    );
    assign cs_s   = pins_s[0];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[2];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            cs_prev_q   <= cs_s;
            sclk_prev_q <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s && !sclk_prev_q && !cs_s;
    assign sclk_fall = !sclk_s && sclk_prev_q && !cs_s;
    assign cs_rise   = cs_s && !cs_prev_q;

    spi_fe_rx #(.OP_W(OP_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_s),
        .bit_rise  (sclk_rise),
        .bit_in    (mosi_s),
        .opcode    (rx_opcode),
        .op_strobe (rx_strobe),
        .exact_len (rx_exact)
    );

    assign id_load = rx_strobe && rx_opcode == OP_ID && !busy;

    spi_fe_tx #(.DW(ID_W), .WORD(ID_WORD)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (cs_s),
        .load     (id_load),
        .bit_fall (sclk_fall),
        .dout     (miso),
        .oe       (miso_oe),
        .active   (tx_active)
    );

    // Hold the opcode of the current selection for the commit at deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
        end else if (rx_strobe) begin
            op_q <= rx_opcode;
        end
    end

    // Selection phase tracker.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            phase_q <= PH_STANDBY;
        end else begin
            unique case (phase_q)
                PH_STANDBY: phase_q <= PH_OPCODE;
                PH_OPCODE:  if (rx_strobe) phase_q <= id_load ? PH_READ : PH_TAIL;
                PH_READ:    if (!tx_active) phase_q <= PH_TAIL;
                PH_TAIL:    phase_q <= PH_TAIL;
            endcase
        end
    end

    // Write-enable latch: completion clears win over a committed set.
    always_ff @(posedge clk) begin
        if (!rst_n || (|op_done)) begin
            wel_q <= 1'b0;
        end else if (cs_rise && rx_exact) begin
            if (op_q == OP_WREN) begin
                wel_q <= 1'b1;
            end else if (op_q == OP_WRDI) begin
                wel_q <= 1'b0;
            end
        end
    end

    assign wel = wel_q;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wel_q && !miso_oe);
    p_set_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(cs_rise && rx_exact && op_q == OP_WREN));
    p_clear_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel_q) |-> $past((|op_done) || (cs_rise && rx_exact && op_q == OP_WRDI)));
    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|op_done) |=> !wel_q);
    p_busy_no_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_opcode == OP_ID && busy) |=> !tx_active);
    p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_STANDBY |-> !miso_oe);
endmodule

// File: tb/spi_flash_cmd_fe_tb.sv
module spi_flash_cmd_fe_tb;
    localparam int HALF = 8;
    localparam logic [23:0] ID_EXP = 24'hC22016;
    // {opcode[7:0], nbits[4:0], busy, exp_wel, exp_id}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {8'h06, 5'd8,  1'b0, 1'b1, 1'b0},
        {8'h04, 5'd8,  1'b0, 1'b0, 1'b0},
        {8'h06, 5'd7,  1'b0, 1'b0, 1'b0},
        {8'h06, 5'd9,  1'b0, 1'b0, 1'b0},
        {8'h06, 5'd8,  1'b0, 1'b1, 1'b0},
        {8'h9F, 5'd8,  1'b0, 1'b1, 1'b1},
        {8'h55, 5'd8,  1'b0, 1'b1, 1'b0},
        {8'h04, 5'd12, 1'b0, 1'b1, 1'b0},
        {8'h9F, 5'd8,  1'b1, 1'b1, 1'b0},
        {8'h06, 5'd8,  1'b1, 1'b1, 1'b0},
        {8'h04, 5'd8,  1'b1, 1'b0, 1'b0},
        {8'h9F, 5'd8,  1'b0, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       busy = 1'b0;
    logic [3:0] op_done = 4'b0;
    logic       miso, miso_oe, wel;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    spi_flash_cmd_fe u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe),
        .busy    (busy),
        .op_done (op_done),
        .wel     (wel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r, output logic o);
        mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        o = miso_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // One selection: nbits command bits (zeros past bit 8), nread data clocks.
    task automatic xfer(input logic [7:0] op, input int nbits, input int nread,
                        output logic [31:0] rdata, output int oe_hi, output logic last_oe);
        logic r, o;
        rdata = '0; oe_hi = 0; last_oe = 1'b0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) sbit((i < 8) ? op[7-i] : 1'b0, r, o);
        for (int j = 0; j < nread; j++) begin
            sbit(1'b0, r, o);
            rdata = {rdata[30:0], r};
            if (o) oe_hi++;
            last_oe = o;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    function automatic string wel_tag(input logic [7:0] op, input int n);
        if (op == 8'h06 && n == 8) return "R2";
        if (op == 8'h04 && n == 8) return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int          oeh;
        logic        lo;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 wel", {31'b0, wel}, 32'd0);
        check("R1 oe", {31'b0, miso_oe}, 32'd0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [7:0] op;
            int nb;
            op = VEC[v][15:8];
            nb = int'(VEC[v][7:3]);
            busy = VEC[v][2];
            xfer(op, nb, (op == 8'h9F) ? 24 : 0, rd, oeh, lo);
            busy = 1'b0;
            check(wel_tag(op, nb), {31'b0, wel}, {31'b0, VEC[v][1]});
            if (op == 8'h9F) begin
                if (VEC[v][0]) begin
                    check("R6 id", rd, {8'h0, ID_EXP});
                    check("R6 oe", oeh, 32'd24);
                end else begin
                    check("R7 oe", oeh, 32'd0);
                end
            end
            check("R9 oe idle", {31'b0, miso_oe}, 32'd0);
        end

        // Each completion pulse clears the latch
        for (int d = 0; d < 4; d++) begin
            xfer(8'h06, 8, 0, rd, oeh, lo);
            check("R2 set", {31'b0, wel}, 32'd1);
            op_done[d] = 1'b1;
            @(negedge clk);
            op_done = '0;
            @(negedge clk);
            check("R5 done clear", {31'b0, wel}, 32'd0);
        end

        // Clear wins over a simultaneous set
        op_done[1] = 1'b1;
        xfer(8'h06, 8, 0, rd, oeh, lo);
        op_done = '0;
        @(negedge clk);
        check("R5 clear wins", {31'b0, wel}, 32'd0);

        // Abort mid-ID, then a normal command
        xfer(8'h9F, 8, 4, rd, oeh, lo);
        check("R8 partial bits", rd, 32'hC);
        check("R8 oe dropped", {31'b0, miso_oe}, 32'd0);
        xfer(8'h06, 8, 0, rd, oeh, lo);
        check("R8 next cmd", {31'b0, wel}, 32'd1);

        // One clock past the ID word
        xfer(8'h9F, 8, 25, rd, oeh, lo);
        check("R9 oe count", oeh, 32'd24);
        check("R9 oe after last", {31'b0, lo}, 32'd0);
        check("R6 id again", rd[24:1], {8'h0, ID_EXP});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule